// File: doc/BRIEF.md
# ADC Conversion Queue Scan Sequencer

This block walks a table of conversion command words and hands them, one at a time, to an external analog-to-digital converter through a start/done handshake. The table is split into two halves. Queue A owns the lower half and queue B owns the upper half. Each queue runs one scan per enable. A scan is launched by one of three sources, picked per queue: a software enable pulse, a level gate input, or a periodic interval timer that both queues share.

Each command word carries a channel number and a pause bit. A channel value of all ones marks the end of the queue. Software writes the table through a simple write port and selects a mode for each queue. It can then read back the per-queue enable, the pause, overrun and completion flags, and the index of the last command each queue completed. A result strobe tells which queue and which table entry every finished conversion belongs to.

Top module: `adcq_scan_seq`

## Requirements
- R1: While `rst` is high, and after it, `sse`, all status flags, `conv_start` and `res_valid` are zero.
- R2: In software mode (`q_mode` code 0), a `sse_set` pulse in cycle c starts the queue at its first table entry, and the first `conv_start` appears in cycle c+2. Channels are issued in table order.
- R3: At most one conversion is outstanding. `conv_start` is a one-cycle pulse. When a queue's next command is ready and `conv_done` is high in cycle k, the next `conv_start` is high in cycle k+2.
- R4: A command whose channel field (bits CH_W-1:0) is all ones ends the queue without a conversion. Completing the last entry of a queue's half also ends it. Either way, the queue's `sse` bit clears and its `cmpl_flag` sets.
- R5: `res_valid` pulses in the cycle after `conv_done`, with `res_queue` and the absolute table index `res_ptr`. The queue's field of `last_ptr` then holds that index.
- R6: In software mode, a command with the pause bit (bit CH_W) set is converted. The queue then halts with `pause_flag` set until the next `sse_set` pulse, and resumes at the following entry.
- R7: In timer mode (`q_mode` code 2), the interval is 2^(7+`tmr_exp`) clock cycles. After a `sse_set` pulse in cycle c, the first `conv_start` is in cycle c + interval + 2.
- R8: In timer mode, a paused queue resumes at the following entry on the next timer elapse.
- R9: A timer elapse that finds a timer-mode queue executing (not armed, not paused) sets that queue's `ovr_flag`. No other case sets it.
- R10: The shared timer is not restarted while any timer-mode queue is still active. With both queues started together, an elapse that resumes a paused queue comes exactly two intervals after the start, even if the other queue has already finished.
- R11: Every new scan starts at the first entry of the queue's half, whatever entry an earlier scan stopped on. Starting a scan clears that queue's flags.
- R12: In gated mode (`q_mode` code 1), an enabled queue waits for its `gate` bit to be high. If the gate closes mid-scan, the conversion in progress completes and nothing more is issued. Then `sse` clears, `pause_flag` sets, `cmpl_flag` stays clear, and `last_ptr` holds the completed entry.
- R13: When both queues are ready in the same cycle, queue A (index 0) is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the converter clock for the timer |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_addr | input | AW | Command table write index |
| tbl_wdata | input | CH_W+1 | Command word: {pause, channel} |
| q_mode | input | 4 | Per-queue mode, 2 bits each, queue A in bits 1:0 |
| sse_set | input | 2 | Per-queue single-scan enable pulse (also resumes a software pause) |
| gate | input | 2 | Per-queue gate level for gated mode |
| tmr_exp | input | TMR_SEL_W | Timer interval exponent offset (interval 2^(7+value)) |
| conv_start | output | 1 | Conversion start pulse to the converter |
| conv_chan | output | CH_W | Channel for the conversion being started |
| conv_done | input | 1 | Converter completion pulse |
| res_valid | output | 1 | Result strobe, one cycle after `conv_done` |
| res_queue | output | 1 | Queue owning the finished conversion |
| res_ptr | output | AW | Table index of the finished conversion |
| sse | output | 2 | Per-queue single-scan enable state |
| pause_flag | output | 2 | Per-queue pause / gate-abort flag |
| ovr_flag | output | 2 | Per-queue trigger overrun flag |
| cmpl_flag | output | 2 | Per-queue end-of-queue flag |
| last_ptr | output | 2*AW | Per-queue index of last completed command, queue A in the low field |

## Verification
The hardest case to reach from the ports is the shared timer outliving one queue. One queue has to reach end of queue while the other sits paused between two elapses. The stimulus starts both queues in timer mode in the same cycle, with a short queue A and a queue B that pauses after its first entry. The bench then times B's resumed conversion against two full intervals. An overrun needs a conversion that is still open when an elapse arrives, so the converter model can hold back `conv_done` for longer than one interval.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  typedef enum logic [1:0] {
    MODE_SW    = 2'd0,
    MODE_GATED = 2'd1,
    MODE_TIMER = 2'd2
  } scan_mode_e;

  typedef enum logic [2:0] {
    Q_IDLE,
    Q_ARMED,
    Q_READY,
    Q_BUSY,
    Q_PAUSED
  } q_state_e;
endpackage

// File: rtl/adcq_cmd_table.sv
module adcq_cmd_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  // distributed-RAM style: one write port, two asynchronous read ports
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/adcq_itimer.sv
module adcq_itimer #(
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17,
  parameter int SEL_W   = 4,
  localparam int CNT_W  = MAX_EXP,
  localparam int SPAN   = MAX_EXP - MIN_EXP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] exp_sel,
  output logic             elapse
);
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel;
  logic [CNT_W:0]   limit;

  always_comb begin
    sel    = (int'(exp_sel) > SPAN) ? SEL_W'(SPAN) : exp_sel;
    limit  = ((CNT_W+1)'(1) << (MIN_EXP + int'(sel))) - (CNT_W+1)'(1);
    elapse = run && ({1'b0, cnt} == limit);
  end

  // counter is held at zero whenever no timer-mode queue is active
  always_ff @(posedge clk) begin
    if (rst || !run || elapse) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adcq_queue_ctl.sv
module adcq_queue_ctl
  import adcq_pkg::*;
#(
  parameter int AW   = 4,
  parameter int CH_W = 5,
  parameter int BASE = 0,
  parameter int LAST = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic            sse_set,
  input  logic            gate,
  input  logic            elapse,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            cmd_pause,
  input  logic            grant,
  input  logic            done,
  output logic            req,
  output logic            tmr_run,
  output logic [AW-1:0]   ptr,
  output logic [AW-1:0]   last_ptr,
  output logic            sse,
  output logic            pause_flag,
  output logic            ovr_flag,
  output logic            cmpl_flag
);
  localparam logic [CH_W-1:0] END_CH = '1;
  localparam logic [AW-1:0]   FIRST  = AW'(BASE);
  localparam logic [AW-1:0]   FINAL  = AW'(LAST);

  q_state_e st;
  logic     cut;
  logic     is_gt, is_tm, is_sw;
  logic     abort, end_hit;

  assign is_gt   = (mode == MODE_GATED);
  assign is_tm   = (mode == MODE_TIMER);
  assign is_sw   = !is_gt && !is_tm;
  assign tmr_run = is_tm && (st != Q_IDLE);

  always_comb begin
    abort   = is_gt && (cut || !gate) && ((st == Q_READY) || (st == Q_PAUSED));
    end_hit = (st == Q_READY) && (cmd_chan == END_CH);
    req     = (st == Q_READY) && !abort && !end_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= Q_IDLE;
      cut        <= 1'b0;
      ptr        <= FIRST;
      last_ptr   <= FIRST;
      sse        <= 1'b0;
      pause_flag <= 1'b0;
      ovr_flag   <= 1'b0;
      cmpl_flag  <= 1'b0;
    end else begin
      if (is_gt && !gate && (st inside {Q_READY, Q_BUSY, Q_PAUSED})) cut <= 1'b1;
      case (st)
        Q_IDLE: if (sse_set) begin
          sse        <= 1'b1;
          ptr        <= FIRST;
          cut        <= 1'b0;
          pause_flag <= 1'b0;
          ovr_flag   <= 1'b0;
          cmpl_flag  <= 1'b0;
          st         <= is_sw ? Q_READY : Q_ARMED;
        end
        Q_ARMED: if ((is_gt && gate) || (is_tm && elapse)) st <= Q_READY;
        Q_READY: begin
          if (abort) begin
            st <= Q_IDLE; sse <= 1'b0; pause_flag <= 1'b1;
          end else if (end_hit) begin
            st <= Q_IDLE; sse <= 1'b0; cmpl_flag <= 1'b1;
          end else if (grant) begin
            st <= Q_BUSY;
          end
        end
        Q_BUSY: if (done) begin
          last_ptr <= ptr;
          if (ptr == FINAL) begin
            st <= Q_IDLE; sse <= 1'b0; cmpl_flag <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
            if (cmd_pause) begin
              st <= Q_PAUSED; pause_flag <= 1'b1;
            end else begin
              st <= Q_READY;
            end
          end
        end
        Q_PAUSED: begin
          if (abort) begin
            st <= Q_IDLE; sse <= 1'b0; pause_flag <= 1'b1;
          end else if ((is_sw && sse_set) || (is_tm && elapse) || is_gt) begin
            st <= Q_READY;
          end
        end
        default: st <= Q_IDLE;
      endcase
      if (is_tm && elapse && ((st == Q_READY) || (st == Q_BUSY))) ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/adcq_scan_seq.sv
module adcq_scan_seq #(
  parameter int CMD_DEPTH   = 16,
  parameter int CH_W        = 5,
  parameter int TMR_MIN_EXP = 7,
  parameter int TMR_MAX_EXP = 17,
  parameter int TMR_SEL_W   = 4,
  localparam int AW         = $clog2(CMD_DEPTH),
  localparam int CW         = CH_W + 1,
  localparam int NQ         = 2,
  localparam int HALF       = CMD_DEPTH / NQ
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [CW-1:0]        tbl_wdata,
  input  logic [2*NQ-1:0]      q_mode,
  input  logic [NQ-1:0]        sse_set,
  input  logic [NQ-1:0]        gate,
  input  logic [TMR_SEL_W-1:0] tmr_exp,
  output logic                 conv_start,
  output logic [CH_W-1:0]      conv_chan,
  input  logic                 conv_done,
  output logic                 res_valid,
  output logic                 res_queue,
  output logic [AW-1:0]        res_ptr,
  output logic [NQ-1:0]        sse,
  output logic [NQ-1:0]        pause_flag,
  output logic [NQ-1:0]        ovr_flag,
  output logic [NQ-1:0]        cmpl_flag,
  output logic [NQ*AW-1:0]     last_ptr
);
  logic [AW-1:0] qptr [NQ];
  logic [CW-1:0] qcmd [NQ];
  logic [NQ-1:0] req, grant, done_q, tmr_run;
  logic          elapse, busy, owner;

  adcq_cmd_table #(.DEPTH(CMD_DEPTH), .DW(CW)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr_a(qptr[0]), .raddr_b(qptr[1]),
    .rdata_a(qcmd[0]), .rdata_b(qcmd[1])
  );

  adcq_itimer #(.MIN_EXP(TMR_MIN_EXP), .MAX_EXP(TMR_MAX_EXP), .SEL_W(TMR_SEL_W)) u_tmr (
    .clk(clk), .rst(rst), .run(|tmr_run), .exp_sel(tmr_exp), .elapse(elapse)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign done_q[q] = busy && conv_done && (owner == 1'(q));
    adcq_queue_ctl #(.AW(AW), .CH_W(CH_W), .BASE(q*HALF), .LAST(q*HALF + HALF - 1)) u_ctl (
      .clk(clk), .rst(rst), .mode(q_mode[2*q +: 2]), .sse_set(sse_set[q]),
      .gate(gate[q]), .elapse(elapse),
      .cmd_chan(qcmd[q][CH_W-1:0]), .cmd_pause(qcmd[q][CH_W]),
      .grant(grant[q]), .done(done_q[q]), .req(req[q]), .tmr_run(tmr_run[q]),
      .ptr(qptr[q]), .last_ptr(last_ptr[q*AW +: AW]), .sse(sse[q]),
      .pause_flag(pause_flag[q]), .ovr_flag(ovr_flag[q]), .cmpl_flag(cmpl_flag[q])
    );
  end

  // fixed priority: queue A ahead of queue B, one conversion at a time
  assign grant[0] = req[0] && !busy;
  assign grant[1] = req[1] && !busy && !req[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      owner      <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      res_valid  <= 1'b0;
      res_queue  <= 1'b0;
      res_ptr    <= '0;
    end else begin
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      if (|grant) begin
        busy       <= 1'b1;
        owner      <= grant[1];
        conv_start <= 1'b1;
        conv_chan  <= grant[1] ? qcmd[1][CH_W-1:0] : qcmd[0][CH_W-1:0];
      end
      if (busy && conv_done) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
        res_queue <= owner;
        res_ptr   <= qptr[owner];
      end
    end
  end
endmodule

// File: rtl/adcq_scan_seq_chk.sv
module adcq_scan_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    q_mode,
  input logic          conv_start,
  input logic          conv_done,
  input logic          res_valid,
  input logic          res_queue,
  input logic [AW-1:0] res_ptr,
  input logic [1:0]    sse,
  input logic [1:0]    ovr_flag,
  input logic [1:0]    cmpl_flag,
  input logic [2*AW-1:0] last_ptr
);
  logic pend;
  always_ff @(posedge clk) begin
    if (rst)             pend <= 1'b0;
    else if (conv_start) pend <= 1'b1;
    else if (conv_done)  pend <= 1'b0;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sse == 2'b00) && !conv_start && !res_valid);

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
    pend |-> !conv_start);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_result_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(conv_done));

  assert_last_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (last_ptr[res_queue*AW +: AW] == res_ptr));

  for (genvar q = 0; q < 2; q++) begin : g_a
    assert_end_clears_sse_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(cmpl_flag[q]) |-> !sse[q]);
    assert_ovr_timer_only_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(ovr_flag[q]) |-> ($past(q_mode[2*q +: 2]) == 2'd2));
  end
endmodule

bind adcq_scan_seq adcq_scan_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .q_mode(q_mode), .conv_start(conv_start),
  .conv_done(conv_done), .res_valid(res_valid), .res_queue(res_queue),
  .res_ptr(res_ptr), .sse(sse), .ovr_flag(ovr_flag), .cmpl_flag(cmpl_flag),
  .last_ptr(last_ptr)
);

// File: tb/sim_adcq_scan_seq.sv
module sim_adcq_scan_seq;
  localparam int AW = 4;
  localparam int P0 = 128;
  localparam logic [5:0] ENDW = 6'h1F;
  localparam logic [5:0] VEC_A [6] = '{6'd3, 6'd7, 6'd12, 6'd1, 6'd20, 6'h1F};

  logic clk = 1'b0, rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [5:0] tbl_wdata = '0;
  logic [3:0] q_mode = '0;
  logic [1:0] sse_set = '0, gate = '0;
  logic [3:0] tmr_exp = '0;
  logic conv_start, conv_done = 1'b0, res_valid, res_queue;
  logic [4:0] conv_chan;
  logic [AW-1:0] res_ptr;
  logic [1:0] sse, pause_flag, ovr_flag, cmpl_flag;
  logic [2*AW-1:0] last_ptr;

  int checks = 0, fails = 0;
  int nlog = 0, lat = 0, hold = 0, gap_mon = 0, gap_bad = 0, cyc = 0, done_cyc = -1;
  logic [4:0] log_ch [64];

  always #5 clk = ~clk;

  adcq_scan_seq u0 (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .q_mode(q_mode), .sse_set(sse_set), .gate(gate), .tmr_exp(tmr_exp),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .res_valid(res_valid), .res_queue(res_queue), .res_ptr(res_ptr),
    .sse(sse), .pause_flag(pause_flag), .ovr_flag(ovr_flag), .cmpl_flag(cmpl_flag),
    .last_ptr(last_ptr)
  );

  // converter model: done three negedges after a start, unless held
  always @(negedge clk) begin
    cyc++;
    conv_done = 1'b0;
    if (conv_start) begin
      if (gap_mon != 0 && done_cyc >= 0 && (cyc - done_cyc) != 2) gap_bad++;
      done_cyc = -1;
      if (nlog < 64) log_ch[nlog] = conv_chan;
      nlog++;
      lat = 3;
    end else if (lat > 0 && hold == 0) begin
      lat--;
      if (lat == 0) begin conv_done = 1'b1; done_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [5:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = AW'(addr); tbl_wdata = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic start_wait(input logic [1:0] m, input logic [4:0] ch, output int k);
    @(negedge clk);
    sse_set = m;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) sse_set = 2'b00;
    end while (!(conv_start && conv_chan == ch) && k < 3000);
  endtask

  task automatic wait_idle(input logic [1:0] m);
    for (int i = 0; i < 3000 && ((sse & m) != 2'b00); i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k, n0;
    repeat (3) @(negedge clk);
    chk(sse == 0 && pause_flag == 0 && ovr_flag == 0 && cmpl_flag == 0, "R1 flags", {sse, pause_flag, ovr_flag, cmpl_flag}, 0);
    chk(!conv_start && !res_valid, "R1 outputs", {conv_start, res_valid}, 0);
    rst = 1'b0;

    // vector walk: software scan of queue A
    for (int i = 0; i < 6; i++) wr(i, VEC_A[i]);
    n0 = nlog;
    gap_mon = 1;
    start_wait(2'b01, VEC_A[0][4:0], k);
    chk(k == 2, "R2 start latency", k, 2);
    wait_idle(2'b01);
    gap_mon = 0;
    for (int i = 0; i < 5; i++)
      chk(log_ch[n0+i] == VEC_A[i][4:0], "R2 channel order", int'(log_ch[n0+i]), int'(VEC_A[i][4:0]));
    chk(nlog - n0 == 5, "R4 end marker not converted", nlog - n0, 5);
    chk(cmpl_flag[0] && !sse[0], "R4 end flags", {cmpl_flag[0], sse[0]}, 2);
    chk(last_ptr[AW-1:0] == 4, "R5 last pointer", int'(last_ptr[AW-1:0]), 4);
    chk(gap_bad == 0, "R3 done to start gap", gap_bad, 0);

    // region end on queue B
    for (int i = 0; i < 8; i++) wr(8 + i, 6'(8 + i));
    n0 = nlog;
    start_wait(2'b10, 5'd8, k);
    wait_idle(2'b10);
    chk(nlog - n0 == 8 && cmpl_flag[1], "R4 region end", nlog - n0, 8);
    chk(last_ptr[2*AW-1:AW] == 15, "R5 last pointer B", int'(last_ptr[2*AW-1:AW]), 15);

    // software pause
    wr(0, 6'h22); wr(1, 6'd4); wr(2, ENDW);
    n0 = nlog;
    start_wait(2'b01, 5'd2, k);
    repeat (20) @(negedge clk);
    chk(pause_flag[0] && sse[0] && nlog - n0 == 1, "R6 paused", nlog - n0, 1);
    start_wait(2'b01, 5'd4, k);
    chk(k == 2, "R6 resume next entry", k, 2);
    wait_idle(2'b01);
    chk(cmpl_flag[0] && nlog - n0 == 2, "R6 completion", nlog - n0, 2);

    // arbitration
    wr(0, 6'd5); wr(1, ENDW); wr(8, 6'd9); wr(9, ENDW);
    n0 = nlog;
    start_wait(2'b11, 5'd5, k);
    wait_idle(2'b11);
    chk(log_ch[n0] == 5 && log_ch[n0+1] == 9, "R13 queue A first", int'(log_ch[n0]), 5);

    // timer start latency for two exponents
    q_mode = 4'b1010;
    wr(0, 6'd6); wr(1, ENDW);
    for (int e = 0; e < 2; e++) begin
      tmr_exp = 4'(e);
      start_wait(2'b01, 5'd6, k);
      chk(k == (P0 << e) + 2, "R7 timer interval", k, (P0 << e) + 2);
      wait_idle(2'b01);
    end
    tmr_exp = 4'd0;

    // timer pause resume
    wr(0, 6'h21); wr(1, 6'd2); wr(2, ENDW);
    start_wait(2'b01, 5'd2, k);
    chk(k == 2*P0 + 2, "R8 resume on elapse", k, 2*P0 + 2);
    wait_idle(2'b01);
    chk(ovr_flag[0] == 0 && cmpl_flag[0], "R9 no spurious overrun", int'(ovr_flag[0]), 0);

    // overrun: conversion held open across an elapse
    wr(0, 6'd1); wr(1, ENDW);
    hold = 1;
    start_wait(2'b01, 5'd1, k);
    repeat (P0 + 10) @(negedge clk);
    chk(ovr_flag[0] == 1, "R9 overrun flagged", int'(ovr_flag[0]), 1);
    hold = 0;
    wait_idle(2'b01);

    // shared timer across both queues
    wr(8, 6'h29); wr(9, 6'd10); wr(10, ENDW);
    start_wait(2'b11, 5'd10, k);
    chk(k == 2*P0 + 2, "R10 shared timer kept", k, 2*P0 + 2);
    chk(sse == 2'b10, "R10 A done while B active", int'(sse), 2);
    wait_idle(2'b11);

    // gated scan with gate closing mid-conversion
    q_mode = 4'b0001;
    gate = 2'b00;
    wr(0, 6'd3); wr(1, 6'd4); wr(2, 6'd5); wr(3, ENDW);
    n0 = nlog;
    @(negedge clk); sse_set = 2'b01;
    @(negedge clk); sse_set = 2'b00;
    repeat (10) @(negedge clk);
    chk(nlog == n0 && sse[0], "R12 waits for gate", nlog - n0, 0);
    gate = 2'b01;
    for (int i = 0; i < 100 && !conv_start; i++) @(negedge clk);
    gate = 2'b00;
    repeat (20) @(negedge clk);
    chk(nlog - n0 == 1, "R12 only current finishes", nlog - n0, 1);
    chk(!sse[0] && pause_flag[0] && !cmpl_flag[0], "R12 abort flags", {sse[0], pause_flag[0], cmpl_flag[0]}, 2);
    chk(last_ptr[AW-1:0] == 0, "R12 last pointer", int'(last_ptr[AW-1:0]), 0);

    // restart always from first entry
    gate = 2'b01;
    n0 = nlog;
    start_wait(2'b01, 5'd3, k);
    wait_idle(2'b01);
    chk(nlog - n0 == 3 && log_ch[n0] == 3 && log_ch[n0+2] == 5, "R11 restart at first entry", int'(log_ch[n0]), 3);
    chk(cmpl_flag[0] && !pause_flag[0], "R11 flags cleared", {cmpl_flag[0], pause_flag[0]}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule